// File: doc/BRIEF.md
# Shared-Cell Storage Window Controller

This block sits between a simple request/response bus and an array of inter-thread communication cells. A single packed configuration word places the storage window in the address map: one bit turns it on, a five-bit field gives its size as a power of two, and the upper bits give its base. Each bus request is tested against that window. A request that lands inside it is split into a cell index and an access view. The cell index comes from the window offset and a programmable stride. The view is a four-bit code that picks the access flavour.

Requests on the five cell views go straight to the cell array through a strobe and carry the cell index. One view code reaches a control word inside this block. That word holds three sticky error flags, which are cleared by writing ones, a three-bit block-grain field that sets the cell stride, and a read-only count of cells. Byte and halfword accesses are refused. They raise the bus-access error flag and return a bus-error response. Every request is answered exactly one cycle later.

Top module: `xt_store_window`

## Requirements
- R1: After reset the configuration word reads 0x22 (window off, size 2^17 bytes, base 0). The control word reads zero flags, zero grain, and NUM_CELLS in the field that starts at bit 16.
- R2: Configuration bit 0 enables the window. While it is 0, no request hits (rsp_hit=0, no cell strobe, no side effect).
- R3: The window base equals the configuration word ANDed with 0xFFFF_FFFF_E000 and shifted left by 4. An address below the base misses.
- R4: The window spans 2^cfg[5:1] bytes from the base. An offset below that size hits and an offset at or above it misses. A miss responds with rsp_hit=0, rsp_err=0, rsp_rdata=0 and has no side effect.
- R5: The view code is address bits [6:3]. Codes 0, 2, 3, 4 and 5 are cell views, code 15 is the control word, and all other codes are undefined.
- R6: The cell index equals the window offset shifted right by (7 + grain), so the stride is 128 bytes times 2^grain.
- R7: A hit with req_size 0 (1 byte) or 1 (2 byte) responds with rsp_err=1 and rsp_rdata=0. It sets control bit 2 (bus-access error), raises no cell strobe and leaves the grain unchanged.
- R8: A control write clears each flag in bits [2:0] whose write-data bit is 1 and leaves the flag alone where the bit is 0. Bit 0 (execution error) and bit 1 (parity error) are set by input pulses. A set wins over a clear in the same cycle.
- R9: Each control write loads the grain field, bits [10:8], from write-data bits [10:8]. No other event changes the grain.
- R10: A read of view 15 returns the control word. A read of an undefined view returns all ones. An access to an undefined view changes nothing.
- R11: A hit of size 4 or 8 bytes (req_size 2 or 3) on a cell view raises cell_req in the same cycle, together with the cell index, view, write flag and write data. A read response returns cell_rdata, and a write response returns 0.
- R12: Every request cycle produces exactly one response (rsp_valid) on the following cycle. No response appears without a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Load the configuration word |
| cfg_wdata | input | 48 | New configuration word |
| cfg_q | output | 48 | Current configuration word |
| req_valid | input | 1 | Bus request present |
| req_write | input | 1 | Request is a write |
| req_addr | input | 52 | Byte address |
| req_size | input | 2 | Access size code: 0=1B, 1=2B, 2=4B, 3=8B |
| req_wdata | input | 64 | Write data |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Request fell inside the enabled window |
| rsp_err | output | 1 | Bus-error response |
| rsp_rdata | output | 64 | Read data |
| cell_req | output | 1 | Cell-array access strobe |
| cell_write | output | 1 | Cell access is a write |
| cell_idx | output | 45 | Selected cell |
| cell_view | output | 4 | Access view code |
| cell_wdata | output | 64 | Write data to the cell |
| cell_rdata | input | 64 | Read data from the selected cell |
| err_exec_set | input | 1 | Pulse that sets the execution error flag |
| err_parity_set | input | 1 | Pulse that sets the parity error flag |

## Verification
The window decode is exercised at addresses just below the base, at the last byte inside the window and at the first byte past it. These three cases separate an off-by-one error in the limit from an error in the base shift, and the same addresses are also tried with the window switched off. Cell-index decoding is tried with grain 0, 3 and 7 at offsets whose results differ for each stride, so a shift that ignores the grain or misplaces the view field gives a wrong index. The control word is driven through flag pulses, clear masks containing both ones and zeros, and a narrow write aimed at it. This shows whether flags are sticky, whether clears act bit by bit, whether a set beats a clear, and whether trapped accesses leave the grain alone.

// File: rtl/xtw_pkg.sv
package xtw_pkg;

   typedef enum logic [3:0] {
      VW_RAW       = 4'd0,
      VW_EF_BLOCK  = 4'd2,
      VW_EF_POLL   = 4'd3,
      VW_SEM_BLOCK = 4'd4,
      VW_SEM_POLL  = 4'd5,
      VW_CTRL      = 4'd15
   } view_e;

   typedef enum logic [1:0] {
      SZ_B1 = 2'd0,
      SZ_B2 = 2'd1,
      SZ_B4 = 2'd2,
      SZ_B8 = 2'd3
   } xfer_size_e;

   localparam int FLAG_EXEC       = 0;
   localparam int FLAG_PARITY     = 1;
   localparam int FLAG_BUS        = 2;
   localparam int FLAG_N          = 3;
   localparam int GRAIN_LSB       = 8;
   localparam int GRAIN_W         = 3;
   localparam int COUNT_LSB       = 16;
   localparam int STRIDE_MIN_LOG2 = 7;
   localparam int VIEW_LSB        = 3;
   localparam int VIEW_W          = 4;
   localparam int SIZE_FLD_LSB    = 1;
   localparam int SIZE_FLD_W      = 5;

   function automatic logic is_cell_view(input logic [VIEW_W-1:0] v);
      case (v)
         VW_RAW, VW_EF_BLOCK, VW_EF_POLL, VW_SEM_BLOCK, VW_SEM_POLL: return 1'b1;
         default: return 1'b0;
      endcase
   endfunction

   function automatic logic is_narrow(input logic [1:0] sz);
      return (xfer_size_e'(sz) == SZ_B1) || (xfer_size_e'(sz) == SZ_B2);
   endfunction

endpackage

// File: rtl/xtw_win_decode.sv
module xtw_win_decode
   import xtw_pkg::*;
#(
   parameter int ADDR_W     = 52,
   parameter int BASE_FLD_W = 35,
   parameter int BASE_POS   = 17
) (
   input  logic                          win_en,
   input  logic [BASE_FLD_W-1:0]         base_fld,
   input  logic [SIZE_FLD_W-1:0]         size_log2,
   input  logic [ADDR_W-1:0]             addr,
   output logic                          hit,
   output logic [ADDR_W-1:VIEW_LSB]      off_hi
);
   localparam int TOP_POS = BASE_POS + BASE_FLD_W;

   generate
      if (TOP_POS > ADDR_W) begin : g_bad_base
         $error("xtw_win_decode: base field does not fit the address width");
      end
      if ((1 << SIZE_FLD_W) > ADDR_W + 1) begin : g_bad_size
         $error("xtw_win_decode: size field can exceed the address width");
      end
   endgenerate

   logic [ADDR_W-1:0] base;
   logic [ADDR_W:0]   diff;
   logic [ADDR_W-1:0] past_end;
   logic              below;

   always_comb begin
      base = '0;
      base[BASE_POS +: BASE_FLD_W] = base_fld;
   end

   assign diff     = {1'b0, addr} - {1'b0, base};
   assign below    = diff[ADDR_W];
   assign past_end = diff[ADDR_W-1:0] >> size_log2;
   assign hit      = win_en & ~below & ~(|past_end);
   assign off_hi   = diff[ADDR_W-1:VIEW_LSB];

endmodule

// File: rtl/xtw_cell_locate.sv
module xtw_cell_locate
   import xtw_pkg::*;
#(
   parameter int ADDR_W = 52,
   parameter int IDX_W  = ADDR_W - STRIDE_MIN_LOG2
) (
   input  logic [ADDR_W-1:VIEW_LSB]  off_hi,
   input  logic [GRAIN_W-1:0]        grain,
   output logic [IDX_W-1:0]          idx,
   output logic [VIEW_W-1:0]         view
);
   localparam int VIEW_TOP = VIEW_LSB + VIEW_W;

   generate
      if (VIEW_TOP != STRIDE_MIN_LOG2) begin : g_bad_view
         $error("xtw_cell_locate: view field must end at the minimum stride");
      end
      if (IDX_W != ADDR_W - STRIDE_MIN_LOG2) begin : g_bad_idx
         $error("xtw_cell_locate: index width must match the address width");
      end
   endgenerate

   logic [IDX_W-1:0] stride_units;

   assign view         = off_hi[VIEW_TOP-1:VIEW_LSB];
   assign stride_units = off_hi[ADDR_W-1:STRIDE_MIN_LOG2];
   assign idx          = stride_units >> grain;

endmodule

// File: rtl/xtw_ctrl_reg.sv
module xtw_ctrl_reg
   import xtw_pkg::*;
#(
   parameter int DATA_W    = 64,
   parameter int NUM_CELLS = 32,
   parameter int COUNT_W   = $clog2(NUM_CELLS + 1)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [FLAG_N-1:0]    wr_clr,
   input  logic [GRAIN_W-1:0]   wr_grain,
   input  logic [FLAG_N-1:0]    flag_set,
   output logic [GRAIN_W-1:0]   grain,
   output logic [DATA_W-1:0]    word
);
   generate
      if (COUNT_LSB + COUNT_W > DATA_W) begin : g_bad_count
         $error("xtw_ctrl_reg: cell count does not fit the data word");
      end
      if (GRAIN_LSB + GRAIN_W > COUNT_LSB) begin : g_bad_grain
         $error("xtw_ctrl_reg: grain field overlaps the cell count");
      end
   endgenerate

   logic [FLAG_N-1:0]  flags_q;
   logic [GRAIN_W-1:0] grain_q;
   logic [COUNT_W-1:0] count_q;

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            flags_q[i] <= 1'b0;
         else if (flag_set[i])
            flags_q[i] <= 1'b1;
         else if (wr_en && wr_clr[i])
            flags_q[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         grain_q <= '0;
      else if (wr_en)
         grain_q <= wr_grain;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         count_q <= COUNT_W'(NUM_CELLS);
   end

   always_comb begin
      word = '0;
      word[FLAG_N-1:0]               = flags_q;
      word[GRAIN_LSB +: GRAIN_W]     = grain_q;
      word[COUNT_LSB +: COUNT_W]     = count_q;
   end

   assign grain = grain_q;

endmodule

// File: rtl/xt_store_window.sv
module xt_store_window
   import xtw_pkg::*;
#(
   parameter int               CFG_W      = 48,
   parameter int               ADDR_W     = 52,
   parameter int               DATA_W     = 64,
   parameter int               NUM_CELLS  = 32,
   parameter int               BASE_LSB   = 13,
   parameter int               BASE_SHIFT = 4,
   parameter logic [CFG_W-1:0] CFG_RESET  = CFG_W'(48'h22),
   localparam int              IDX_W      = ADDR_W - STRIDE_MIN_LOG2
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 cfg_we,
   input  logic [CFG_W-1:0]     cfg_wdata,
   output logic [CFG_W-1:0]     cfg_q,
   input  logic                 req_valid,
   input  logic                 req_write,
   input  logic [ADDR_W-1:0]    req_addr,
   input  logic [1:0]           req_size,
   input  logic [DATA_W-1:0]    req_wdata,
   output logic                 rsp_valid,
   output logic                 rsp_hit,
   output logic                 rsp_err,
   output logic [DATA_W-1:0]    rsp_rdata,
   output logic                 cell_req,
   output logic                 cell_write,
   output logic [IDX_W-1:0]     cell_idx,
   output logic [VIEW_W-1:0]    cell_view,
   output logic [DATA_W-1:0]    cell_wdata,
   input  logic [DATA_W-1:0]    cell_rdata,
   input  logic                 err_exec_set,
   input  logic                 err_parity_set
);
   localparam int BASE_FLD_W = CFG_W - BASE_LSB;
   localparam int BASE_POS   = BASE_LSB + BASE_SHIFT;
   localparam int COUNT_W    = $clog2(NUM_CELLS + 1);

   generate
      if (BASE_LSB <= SIZE_FLD_LSB + SIZE_FLD_W) begin : g_bad_cfg
         $error("xt_store_window: base field overlaps the size field");
      end
      if (DATA_W < COUNT_LSB + COUNT_W) begin : g_bad_data
         $error("xt_store_window: data word too narrow for the control word");
      end
      if (NUM_CELLS < 1) begin : g_bad_cells
         $error("xt_store_window: at least one cell is required");
      end
   endgenerate

   // configuration word
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cfg_q <= CFG_RESET;
      else if (cfg_we)
         cfg_q <= cfg_wdata;
   end

   // window decode
   logic                      win_hit;
   logic [ADDR_W-1:VIEW_LSB]  win_off_hi;

   xtw_win_decode #(
      .ADDR_W     (ADDR_W),
      .BASE_FLD_W (BASE_FLD_W),
      .BASE_POS   (BASE_POS)
   ) u_dec (
      .win_en    (cfg_q[0]),
      .base_fld  (cfg_q[CFG_W-1:BASE_LSB]),
      .size_log2 (cfg_q[SIZE_FLD_LSB +: SIZE_FLD_W]),
      .addr      (req_addr),
      .hit       (win_hit),
      .off_hi    (win_off_hi)
   );

   // cell and view selection
   logic [GRAIN_W-1:0] grain;
   logic [IDX_W-1:0]   loc_idx;
   logic [VIEW_W-1:0]  loc_view;

   xtw_cell_locate #(
      .ADDR_W (ADDR_W),
      .IDX_W  (IDX_W)
   ) u_loc (
      .off_hi (win_off_hi),
      .grain  (grain),
      .idx    (loc_idx),
      .view   (loc_view)
   );

   // request classification
   logic narrow;
   logic acc_ok;
   logic bus_err_set;
   logic ctrl_wr;
   logic view_cell;
   logic view_ctrl;

   assign narrow      = is_narrow(req_size);
   assign view_cell   = is_cell_view(loc_view);
   assign view_ctrl   = (loc_view == VW_CTRL);
   assign acc_ok      = req_valid & win_hit & ~narrow;
   assign bus_err_set = req_valid & win_hit & narrow;
   assign ctrl_wr     = acc_ok & req_write & view_ctrl;

   // control word
   logic [DATA_W-1:0] ctrl_word;
   logic [FLAG_N-1:0] flag_set;

   always_comb begin
      flag_set              = '0;
      flag_set[FLAG_EXEC]   = err_exec_set;
      flag_set[FLAG_PARITY] = err_parity_set;
      flag_set[FLAG_BUS]    = bus_err_set;
   end

   xtw_ctrl_reg #(
      .DATA_W    (DATA_W),
      .NUM_CELLS (NUM_CELLS),
      .COUNT_W   (COUNT_W)
   ) u_ctrl (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (ctrl_wr),
      .wr_clr   (req_wdata[FLAG_N-1:0]),
      .wr_grain (req_wdata[GRAIN_LSB +: GRAIN_W]),
      .flag_set (flag_set),
      .grain    (grain),
      .word     (ctrl_word)
   );

   // cell array side
   assign cell_req   = acc_ok & view_cell;
   assign cell_write = req_write;
   assign cell_idx   = loc_idx;
   assign cell_view  = loc_view;
   assign cell_wdata = req_wdata;

   // response
   logic [DATA_W-1:0] rdata_d;

   always_comb begin
      rdata_d = '0;
      if (acc_ok && !req_write) begin
         if (view_ctrl)
            rdata_d = ctrl_word;
         else if (view_cell)
            rdata_d = cell_rdata;
         else
            rdata_d = '1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid & win_hit;
         rsp_err   <= bus_err_set;
         rsp_rdata <= rdata_d;
      end
   end

endmodule

// File: rtl/xtw_window_chk.sv
module xtw_window_chk #(
   parameter int DATA_W = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              win_en,
   input logic              req_valid,
   input logic              win_hit,
   input logic              narrow,
   input logic              ctrl_wr,
   input logic              cell_req,
   input logic              rsp_valid,
   input logic              rsp_hit,
   input logic              rsp_err,
   input logic [DATA_W-1:0] rsp_rdata,
   input logic [2:0]        flags,
   input logic [2:0]        grain,
   input logic [7:0]        count
);

   a_r2_off_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
      !win_en |-> !win_hit);

   a_r7_narrow_trap: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && win_hit && narrow) |=> (rsp_err && rsp_rdata == '0 && flags[2]));

   a_r7_narrow_no_cell: assert property (@(posedge clk) disable iff (!rst_n)
      narrow |-> !cell_req);

   a_r4_miss_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !win_hit) |=> (!rsp_hit && !rsp_err && rsp_rdata == '0));

   a_r8_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (flags[0] && !ctrl_wr) |=> flags[0]);

   a_r9_grain_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_wr |=> $stable(grain));

   a_r1_count_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> $stable(count));

   a_r12_rsp_follows: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);

   a_r12_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);

   a_r11_cell_in_window: assert property (@(posedge clk) disable iff (!rst_n)
      cell_req |-> (req_valid && win_hit));

endmodule

bind xt_store_window xtw_window_chk #(.DATA_W(DATA_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .win_en    (cfg_q[0]),
   .req_valid (req_valid),
   .win_hit   (win_hit),
   .narrow    (narrow),
   .ctrl_wr   (ctrl_wr),
   .cell_req  (cell_req),
   .rsp_valid (rsp_valid),
   .rsp_hit   (rsp_hit),
   .rsp_err   (rsp_err),
   .rsp_rdata (rsp_rdata),
   .flags     (ctrl_word[2:0]),
   .grain     (ctrl_word[10:8]),
   .count     (ctrl_word[23:16])
);

// File: tb/xt_store_window_tb.sv
module xt_store_window_tb;

   localparam int CFG_W = 48;
   localparam int ADDR_W = 52;
   localparam int DATA_W = 64;
   localparam int NCELL = 32;
   localparam int IDX_W = ADDR_W - 7;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              cfg_we = 1'b0;
   logic [CFG_W-1:0]  cfg_wdata = '0;
   logic [CFG_W-1:0]  cfg_q;
   logic              req_valid = 1'b0;
   logic              req_write = 1'b0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic [1:0]        req_size = 2'd3;
   logic [DATA_W-1:0] req_wdata = '0;
   logic              rsp_valid, rsp_hit, rsp_err;
   logic [DATA_W-1:0] rsp_rdata;
   logic              cell_req, cell_write;
   logic [IDX_W-1:0]  cell_idx;
   logic [3:0]        cell_view;
   logic [DATA_W-1:0] cell_wdata;
   logic [DATA_W-1:0] cell_rdata;
   logic              err_exec_set = 1'b0;
   logic              err_parity_set = 1'b0;

   always #4 clk = ~clk;

   // cell array stand-in: data tagged with the selected index
   assign cell_rdata = 64'hFEED_0000_0000_0000 | {19'b0, cell_idx};

   xt_store_window u_dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_q(cfg_q),
      .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
      .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .cell_req(cell_req), .cell_write(cell_write), .cell_idx(cell_idx),
      .cell_view(cell_view), .cell_wdata(cell_wdata), .cell_rdata(cell_rdata),
      .err_exec_set(err_exec_set), .err_parity_set(err_parity_set)
   );

   int total = 0;
   int bad = 0;
   bit done = 0;

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   // requirement model
   logic [CFG_W-1:0] m_cfg = 48'h22;
   logic [2:0]       m_flags = 3'b000;
   logic [2:0]       m_grain = 3'd0;

   function automatic logic [ADDR_W-1:0] m_base();
      logic [ADDR_W-1:0] b = '0;
      b[ADDR_W-1:17] = m_cfg[CFG_W-1:13];
      return b;
   endfunction

   function automatic bit m_hit(input logic [ADDR_W-1:0] a);
      logic [ADDR_W-1:0] b = m_base();
      if (!m_cfg[0] || a < b) return 0;
      return ((a - b) >> m_cfg[5:1]) == 0;
   endfunction

   function automatic logic [63:0] m_ctrl();
      return (64'(NCELL) << 16) | (64'(m_grain) << 8) | 64'(m_flags);
   endfunction

   typedef struct {
      logic        hit;
      logic        err;
      logic [63:0] rdata;
      string       tag;
   } exp_t;

   exp_t sb[$];

   // driver: one request, expected response pushed to the scoreboard
   task automatic do_req(input bit wr, input logic [ADDR_W-1:0] a, input logic [1:0] sz,
                         input logic [63:0] wd, input string tag);
      exp_t e;
      logic [ADDR_W-1:0] off;
      logic [3:0] v;
      logic [IDX_W-1:0] idx;
      bit hit, nar, cv;
      @(negedge clk);
      req_valid = 1'b1; req_write = wr; req_addr = a; req_size = sz; req_wdata = wd;
      hit = m_hit(a);
      nar = (sz < 2);
      off = a - m_base();
      v = off[6:3];
      idx = IDX_W'(off >> (7 + m_grain));
      cv = (v == 0) || (v == 2) || (v == 3) || (v == 4) || (v == 5);
      #1;
      chk(cell_req == (hit && !nar && cv), {tag, " cell strobe"}, 64'(cell_req), 64'(hit && !nar && cv));
      if (hit && !nar && cv) begin
         chk(cell_idx == idx, {tag, " cell index"}, 64'(cell_idx), 64'(idx));
         chk(cell_view == v, {tag, " cell view"}, 64'(cell_view), 64'(v));
         chk(cell_write == wr && cell_wdata == wd, {tag, " cell write data"}, cell_wdata, wd);
      end
      e.hit = hit; e.err = hit && nar; e.tag = tag;
      e.rdata = 64'h0;
      if (hit && !nar && !wr) begin
         if (v == 15) e.rdata = m_ctrl();
         else if (cv) e.rdata = 64'hFEED_0000_0000_0000 | {19'b0, idx};
         else e.rdata = '1;
      end
      sb.push_back(e);
      if (hit && nar) m_flags[2] = 1'b1;
      if (hit && !nar && wr && v == 15) begin
         m_flags = m_flags & ~wd[2:0];
         m_grain = wd[10:8];
      end
      @(negedge clk);
      req_valid = 1'b0; req_write = 1'b0;
   endtask

   // monitor: compare responses in order (R12 pacing)
   always @(negedge clk) begin
      if (rst_n && rsp_valid && !done) begin
         if (sb.size() == 0) begin
            chk(0, "R12 unexpected response", 64'(rsp_valid), 64'h0);
         end else begin
            exp_t e;
            e = sb.pop_front();
            chk(rsp_hit == e.hit, {e.tag, " rsp_hit"}, 64'(rsp_hit), 64'(e.hit));
            chk(rsp_err == e.err, {e.tag, " rsp_err"}, 64'(rsp_err), 64'(e.err));
            chk(rsp_rdata == e.rdata, {e.tag, " rsp_rdata"}, rsp_rdata, e.rdata);
         end
      end
   end

   task automatic write_cfg(input logic [CFG_W-1:0] v);
      @(negedge clk);
      cfg_we = 1'b1; cfg_wdata = v;
      @(negedge clk);
      cfg_we = 1'b0;
      m_cfg = v;
      chk(cfg_q == v, "R3 config load", 64'(cfg_q), 64'(v));
   endtask

   task automatic pulse_flags(input bit ex, input bit par);
      @(negedge clk);
      err_exec_set = ex; err_parity_set = par;
      @(negedge clk);
      err_exec_set = 1'b0; err_parity_set = 1'b0;
      if (ex) m_flags[0] = 1'b1;
      if (par) m_flags[1] = 1'b1;
   endtask

   localparam logic [ADDR_W-1:0] BASE = 52'h40000;
   localparam logic [ADDR_W-1:0] CTRL_OFF = 52'h78;

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(cfg_q == 48'h22, "R1 config reset", 64'(cfg_q), 64'h22);
      chk(rsp_valid == 1'b0, "R1 no response at reset", 64'(rsp_valid), 64'h0);

      // R2: window off at reset, address inside the nominal span
      do_req(0, 52'h80, 2'd3, 0, "R2 disabled");
      do_req(0, CTRL_OFF, 2'd3, 0, "R2 disabled ctrl");

      // enable at base 0, read control word reset value (R1, R10)
      write_cfg(48'h23);
      do_req(0, CTRL_OFF, 2'd3, 0, "R1 ctrl reset R10");

      // base 0x40000, size 2^16
      write_cfg(48'h4021);
      do_req(0, BASE - 8, 2'd3, 0, "R3 below base");
      do_req(0, BASE + 52'hFFF8, 2'd3, 0, "R4 last byte");
      do_req(0, BASE + 52'h10000, 2'd3, 0, "R4 past end");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R10 ctrl read");

      // cell views with grain 0 (R5, R6, R11)
      do_req(1, BASE + 5*128 + (2 << 3), 2'd2, 64'h1234_5678, "R11 write view2 R6");
      do_req(0, BASE + 3*128 + (5 << 3), 2'd3, 0, "R11 read view5 R5");
      do_req(0, BASE + 9*128, 2'd2, 0, "R11 read view0");

      // undefined views (R10)
      do_req(0, BASE + (7 << 3), 2'd3, 0, "R10 undefined read");
      do_req(1, BASE + (9 << 3), 2'd3, 64'h707, "R10 undefined write");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R10 ctrl untouched");

      // narrow accesses (R7)
      do_req(0, BASE + (2 << 3), 2'd0, 0, "R7 byte read");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R7 bus flag set");
      do_req(1, BASE + CTRL_OFF, 2'd1, 64'h707, "R7 half write to ctrl");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R7 grain kept");

      // flag pulses and write-one-to-clear (R8), grain load (R9)
      pulse_flags(1, 1);
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R8 all flags");
      do_req(1, BASE + CTRL_OFF, 2'd3, 64'h302, "R8 clear parity R9");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R8 partial clear R9");
      do_req(1, BASE + 3*1024 + (4 << 3), 2'd3, 64'hABCD, "R6 grain3 stride");
      do_req(1, BASE + CTRL_OFF, 2'd3, 64'h0, "R8 zero mask R9");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R8 flags kept R9 grain0");

      // set wins over clear in the same cycle (R8)
      @(negedge clk);
      err_exec_set = 1'b1;
      req_valid = 1'b1; req_write = 1'b1; req_addr = BASE + CTRL_OFF; req_size = 2'd3; req_wdata = 64'h1;
      begin
         exp_t e;
         e.hit = 1; e.err = 0; e.rdata = 0; e.tag = "R8 set beats clear";
         sb.push_back(e);
      end
      @(negedge clk);
      err_exec_set = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      m_grain = 3'd0;
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R8 set beats clear readback");

      // grain 7 (R6, R9), clear all flags
      do_req(1, BASE + CTRL_OFF, 2'd3, 64'h707, "R9 grain7 R8 clear all");
      do_req(0, BASE + 52'hC000 + (3 << 3), 2'd3, 0, "R6 grain7 stride");
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R9 grain7 readback");

      // disable again (R2)
      write_cfg(48'h4020);
      do_req(0, BASE + CTRL_OFF, 2'd3, 0, "R2 disabled again");
      do_req(1, BASE + 128, 2'd3, 64'h5, "R2 no cell strobe");

      repeat (3) @(negedge clk);
      chk(sb.size() == 0, "R12 all responses seen", 64'(sb.size()), 64'h0);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(8 * 20000);
      if (!done) begin
         done = 1;
         chk(0, "R12 watchdog", 64'h0, 64'h1);
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule